// File: doc/BRIEF.md
# Hierarchical Bandwidth Cap Limiter

This block throttles the memory bandwidth that each partition of a processing element may use. It applies two levels of programmed limit. A guest supplies a maximum for each execution context. A hypervisor supplies one cap register, which bounds whichever guest maximum is in force. The block picks the guest maximum from three inputs: the current privilege level, the streaming-mode flag and the two host-mode bits. It then takes the smaller of that maximum and the cap, when the cap applies, and turns the result into a byte budget for one accounting window.

Traffic is reported one request at a time as a partition ID and a byte count. The block keeps a running byte total for each partition. A partition whose total goes over the budget is flagged as blocked until the window ends. At the end of the window every total is cleared.

All limits use unsigned 16.16 fixed point, where 1.0 stands for the whole of the available bandwidth.

Top module: `bw_cap_limiter`

## Requirements
- R1: While reset is asserted and after it is released, the cap register reads as all zero, the cap is disabled and no partition is blocked.
- R2: A write stores bit 63 as the scale-enable flag (only when parameter HAS_HWS is 1, otherwise that bit reads 0) and bit 62 as the cap-enable flag. Bits 61:32 always read as zero.
- R3: When the written scale-enable flag is 1, bits 31:16 hold the integer part of the cap and bits 15:0 its fraction, so the cap is a multiplier of the available bandwidth.
- R4: When the written scale-enable flag is 0, bits 31:16 read as zero and bits 15:0 hold the cap as a fraction of the available bandwidth.
- R5: Only the top FRAC_W fraction bits, counted down from bit 15, are kept. Fraction bits below bit 16-FRAC_W read as zero.
- R6: The guest maximum is chosen as follows. At level 1 it is the streaming maximum if streaming is 1, else the level-1 maximum. At level 0 it is the streaming maximum if streaming is 1, else the level-0 maximum. At levels 2 and 3 it is always the level-1 maximum.
- R7: The cap applies only when all three of these hold: the cap-enable flag is 1, hyp_active is 1, and either the level is 1 or the level is 0 with host_bits not equal to 2'b11. When it applies, eff_limit is the smaller of the chosen maximum and the cap; a fraction-format cap takes the same 16.16 scale as the maximum by zero-extension. When it does not apply, eff_limit is the chosen maximum.
- R8: Each partition accumulates the req_bytes of its valid requests. part_blocked[p] is 1 while that partition's total is greater than floor(eff_limit * WIN_BYTES / 65536).
- R9: Every WIN_CYC cycles all totals clear. A request presented in the clearing cycle is not counted, and every part_blocked bit is 0 in the cycle after the clear.
- R10: req_blocked equals part_blocked at index req_partid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Write strobe for the cap register |
| cfg_wr_data | input | 64 | Cap register write value |
| cfg_rd_data | output | 64 | Cap register read value |
| cur_lvl | input | 2 | Current privilege level, 0 to 3 |
| host_bits | input | 2 | Host-mode bits; host mode when both are 1 |
| streaming | input | 1 | Streaming execution mode active |
| hyp_active | input | 1 | Hypervisor level enabled in the current security state |
| gmax_lvl0 | input | 32 | Guest maximum for level 0, 16.16 |
| gmax_lvl1 | input | 32 | Guest maximum for level 1, 16.16 |
| gmax_strm | input | 32 | Guest maximum for streaming mode, 16.16 |
| req_valid | input | 1 | A request is reported this cycle |
| req_partid | input | PART_W | Partition of the request |
| req_bytes | input | BYTES_W | Bytes moved by the request |
| eff_limit | output | 32 | Effective limit, 16.16 |
| part_blocked | output | 2**PART_W | Per-partition blocked flags |
| req_blocked | output | 1 | Blocked flag of the partition on req_partid |

## Verification
The hardest case to reach from the ports is a request that falls exactly on the window-clearing cycle. The window counter is not visible, so the bench first finds its phase. It overdrives partition 0 until that partition is blocked, then stops and waits for the flag to drop, which marks a clear edge. From then on the bench keeps its own phase count. In every clearing cycle it deliberately presents a full-size request, so the discard can be seen at part_blocked. The limit selection is swept over every combination of level, host bits, streaming flag, hyp_active, enable flag and format.

// File: rtl/bw_cap_pkg.sv
package bw_cap_pkg;

  localparam int FIX_FRAC = 16;

  typedef struct packed {
    logic        scale_en;
    logic        cap_en;
    logic [31:0] cap;
  } cap_cfg_t;

  typedef enum logic [1:0] {
    LVL_USER   = 2'd0,
    LVL_KERNEL = 2'd1,
    LVL_HYP    = 2'd2,
    LVL_MON    = 2'd3
  } priv_lvl_e;

endpackage

// File: rtl/bwc_cfg_reg.sv
module bwc_cfg_reg
  import bw_cap_pkg::*;
#(
  parameter int FRAC_W  = 12,
  parameter bit HAS_HWS = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [63:0] wr_data,
  output cap_cfg_t    cfg,
  output logic [63:0] rd_data
);

  localparam logic [31:0] ONES_W = (32'd1 << FRAC_W) - 32'd1;
  localparam logic [15:0] FMASK  = ONES_W[15:0] << (16 - FRAC_W);

  cap_cfg_t cfg_q, cfg_nxt;

  always_comb begin
    cfg_nxt.scale_en = HAS_HWS ? wr_data[63] : 1'b0;
    cfg_nxt.cap_en   = wr_data[62];
    if (cfg_nxt.scale_en) begin
      cfg_nxt.cap = {wr_data[31:16], wr_data[15:0] & FMASK};
    end else begin
      cfg_nxt.cap = {16'h0000, wr_data[15:0] & FMASK};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= cfg_nxt;
    end
  end

  assign cfg     = cfg_q;
  assign rd_data = {cfg_q.scale_en, cfg_q.cap_en, 30'd0, cfg_q.cap};

endmodule

// File: rtl/bwc_limit_sel.sv
module bwc_limit_sel
  import bw_cap_pkg::*;
(
  input  cap_cfg_t    cfg,
  input  logic [1:0]  cur_lvl,
  input  logic [1:0]  host_bits,
  input  logic        streaming,
  input  logic        hyp_active,
  input  logic [31:0] gmax_lvl0,
  input  logic [31:0] gmax_lvl1,
  input  logic [31:0] gmax_strm,
  output logic [31:0] eff_limit
);

  logic        host_mode;
  logic        lvl_capped;
  logic        cap_on;
  logic [31:0] sel_max;
  logic [31:0] cap_fix;

  assign host_mode = &host_bits;

  always_comb begin
    unique case (priv_lvl_e'(cur_lvl))
      LVL_KERNEL: begin
        sel_max    = streaming ? gmax_strm : gmax_lvl1;
        lvl_capped = 1'b1;
      end
      LVL_USER: begin
        sel_max    = streaming ? gmax_strm : gmax_lvl0;
        lvl_capped = !host_mode;
      end
      default: begin
        sel_max    = gmax_lvl1;
        lvl_capped = 1'b0;
      end
    endcase
  end

  // Fraction-format cap sits in the low half; zero-extend to 16.16.
  assign cap_fix = cfg.scale_en ? cfg.cap : {16'h0000, cfg.cap[15:0]};
  assign cap_on  = cfg.cap_en && hyp_active && lvl_capped;

  always_comb begin
    if (cap_on && (cap_fix < sel_max)) begin
      eff_limit = cap_fix;
    end else begin
      eff_limit = sel_max;
    end
  end

endmodule

// File: rtl/bwc_usage_acct.sv
module bwc_usage_acct #(
  parameter int PART_W  = 2,
  parameter int BYTES_W = 8,
  parameter int WIN_CYC = 16,
  parameter int CNT_W   = 26
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [PART_W-1:0]       req_partid,
  input  logic [BYTES_W-1:0]      req_bytes,
  input  logic [CNT_W-1:0]        limit_bytes,
  output logic [(1<<PART_W)-1:0]  blocked,
  output logic                    win_wrap
);

  localparam int NPART = 1 << PART_W;
  localparam int WIN_W = $clog2(WIN_CYC);
  localparam int SUM_W = CNT_W + 1;

  logic [WIN_W-1:0] win_q, win_nxt;

  assign win_wrap = (win_q == WIN_W'(WIN_CYC - 1));
  assign win_nxt  = win_wrap ? '0 : win_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else begin
      win_q <= win_nxt;
    end
  end

  for (genvar p = 0; p < NPART; p++) begin : g_part
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic [SUM_W-1:0] sum;
    logic             hit;
    logic             cnt_en;

    assign hit    = req_valid && (req_partid == PART_W'(p));
    assign sum    = {1'b0, cnt_q} + SUM_W'(req_bytes);
    assign cnt_en = win_wrap || hit;

    always_comb begin
      if (win_wrap) begin
        cnt_nxt = '0;
      end else if (sum[CNT_W]) begin
        cnt_nxt = '1;
      end else begin
        cnt_nxt = sum[CNT_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (cnt_en) begin
        cnt_q <= cnt_nxt;
      end
    end

    assign blocked[p] = (cnt_q > limit_bytes);
  end

endmodule

// File: rtl/bw_cap_limiter.sv
module bw_cap_limiter
  import bw_cap_pkg::*;
#(
  parameter int PART_W    = 2,
  parameter int BYTES_W   = 8,
  parameter int WIN_CYC   = 16,
  parameter int WIN_BYTES = 256,
  parameter int FRAC_W    = 12,
  parameter bit HAS_HWS   = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_wr_en,
  input  logic [63:0]             cfg_wr_data,
  output logic [63:0]             cfg_rd_data,
  input  logic [1:0]              cur_lvl,
  input  logic [1:0]              host_bits,
  input  logic                    streaming,
  input  logic                    hyp_active,
  input  logic [31:0]             gmax_lvl0,
  input  logic [31:0]             gmax_lvl1,
  input  logic [31:0]             gmax_strm,
  input  logic                    req_valid,
  input  logic [PART_W-1:0]       req_partid,
  input  logic [BYTES_W-1:0]      req_bytes,
  output logic [31:0]             eff_limit,
  output logic [(1<<PART_W)-1:0]  part_blocked,
  output logic                    req_blocked
);

  localparam int WB_W   = $clog2(WIN_BYTES + 1);
  localparam int PROD_W = 32 + WB_W;
  localparam int LIM_W  = PROD_W - FIX_FRAC;
  localparam int CNT_W  = LIM_W + 1;

  logic             rst_s1_q, rst_s2_q;
  cap_cfg_t         cfg;
  logic [PROD_W-1:0] prod;
  logic [CNT_W-1:0] limit_bytes;
  logic             win_wrap;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  bwc_cfg_reg #(
    .FRAC_W  (FRAC_W),
    .HAS_HWS (HAS_HWS)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_s2_q),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .cfg     (cfg),
    .rd_data (cfg_rd_data)
  );

  bwc_limit_sel u_sel (
    .cfg        (cfg),
    .cur_lvl    (cur_lvl),
    .host_bits  (host_bits),
    .streaming  (streaming),
    .hyp_active (hyp_active),
    .gmax_lvl0  (gmax_lvl0),
    .gmax_lvl1  (gmax_lvl1),
    .gmax_strm  (gmax_strm),
    .eff_limit  (eff_limit)
  );

  assign prod        = PROD_W'(eff_limit) * PROD_W'(WIN_BYTES);
  assign limit_bytes = CNT_W'(prod[PROD_W-1:FIX_FRAC]);

  bwc_usage_acct #(
    .PART_W  (PART_W),
    .BYTES_W (BYTES_W),
    .WIN_CYC (WIN_CYC),
    .CNT_W   (CNT_W)
  ) u_acct (
    .clk         (clk),
    .rst_n       (rst_s2_q),
    .req_valid   (req_valid),
    .req_partid  (req_partid),
    .req_bytes   (req_bytes),
    .limit_bytes (limit_bytes),
    .blocked     (part_blocked),
    .win_wrap    (win_wrap)
  );

  assign req_blocked = part_blocked[req_partid];

endmodule

// File: rtl/bw_cap_limiter_chk.sv
module bw_cap_limiter_chk #(
  parameter int NPART  = 4,
  parameter int FRAC_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [63:0]       cfg_rd_data,
  input logic [31:0]       eff_limit,
  input logic [NPART-1:0]  part_blocked,
  input logic [1:0]        cur_lvl,
  input logic [1:0]        host_bits,
  input logic              hyp_active,
  input logic [31:0]       gmax_lvl1,
  input logic              win_wrap
);

  localparam logic [31:0] ONES_W = (32'd1 << FRAC_W) - 32'd1;
  localparam logic [15:0] LOWM   = ~(ONES_W[15:0] << (16 - FRAC_W));

  logic        cap_applies;
  logic [31:0] cap_seen;

  assign cap_applies = cfg_rd_data[62] && hyp_active &&
                       ((cur_lvl == 2'd1) || ((cur_lvl == 2'd0) && (host_bits != 2'b11)));
  assign cap_seen    = cfg_rd_data[63] ? cfg_rd_data[31:0] : {16'h0000, cfg_rd_data[15:0]};

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[61:32] == 30'd0);

  a_r4_frac_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd_data[63] |-> (cfg_rd_data[31:16] == 16'h0000));

  a_r5_low_frac_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data[15:0] & LOWM) == 16'h0000);

  a_r7_cap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cap_applies |-> (eff_limit <= cap_seen));

  a_r6_upper_lvl_uncapped: assert property (@(posedge clk) disable iff (!rst_n)
    cur_lvl[1] |-> (eff_limit == gmax_lvl1));

  a_r9_clear_unblocks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(win_wrap) |-> (part_blocked == '0));

endmodule

bind bw_cap_limiter bw_cap_limiter_chk #(
  .NPART  (1 << PART_W),
  .FRAC_W (FRAC_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_rd_data  (cfg_rd_data),
  .eff_limit    (eff_limit),
  .part_blocked (part_blocked),
  .cur_lvl      (cur_lvl),
  .host_bits    (host_bits),
  .hyp_active   (hyp_active),
  .gmax_lvl1    (gmax_lvl1),
  .win_wrap     (win_wrap)
);

// File: tb/bw_cap_limiter_test.sv
`timescale 1ns/1ps
module bw_cap_limiter_test;

  localparam int PART_W    = 2;
  localparam int NPART     = 1 << PART_W;
  localparam int BYTES_W   = 8;
  localparam int WIN_CYC   = 16;
  localparam int WIN_BYTES = 256;
  localparam int FRAC_W    = 12;
  localparam logic [15:0] FM = 16'hFFF0;

  logic clk, rst_n;
  logic cfg_wr_en;
  logic [63:0] cfg_wr_data, cfg_rd_data;
  logic [1:0]  cur_lvl, host_bits;
  logic        streaming, hyp_active;
  logic [31:0] gmax_lvl0, gmax_lvl1, gmax_strm;
  logic        req_valid;
  logic [PART_W-1:0]  req_partid;
  logic [BYTES_W-1:0] req_bytes;
  logic [31:0] eff_limit;
  logic [NPART-1:0] part_blocked;
  logic        req_blocked;

  int checks = 0;
  int errors = 0;

  bw_cap_limiter #(
    .PART_W(PART_W), .BYTES_W(BYTES_W), .WIN_CYC(WIN_CYC),
    .WIN_BYTES(WIN_BYTES), .FRAC_W(FRAC_W), .HAS_HWS(1'b1)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .cur_lvl(cur_lvl), .host_bits(host_bits),
    .streaming(streaming), .hyp_active(hyp_active), .gmax_lvl0(gmax_lvl0),
    .gmax_lvl1(gmax_lvl1), .gmax_strm(gmax_strm), .req_valid(req_valid),
    .req_partid(req_partid), .req_bytes(req_bytes), .eff_limit(eff_limit),
    .part_blocked(part_blocked), .req_blocked(req_blocked)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference state
  logic [63:0] rd_exp;
  bit          synced = 0;
  int          phase  = 0;
  longint      cnt [NPART];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_rd(input logic [63:0] d);
    logic [31:0] c;
    c = d[63] ? {d[31:16], d[15:0] & FM} : {16'h0000, d[15:0] & FM};
    return {d[63], d[62], 30'd0, c};
  endfunction

  function automatic logic [31:0] model_eff(input logic [63:0] rd);
    logic [31:0] sel;
    logic [31:0] capv;
    bit on;
    if (cur_lvl == 2'd1) sel = streaming ? gmax_strm : gmax_lvl1;
    else if (cur_lvl == 2'd0) sel = streaming ? gmax_strm : gmax_lvl0;
    else sel = gmax_lvl1;
    capv = rd[31:0];
    on = rd[62] && hyp_active && (cur_lvl == 2'd1 || (cur_lvl == 2'd0 && host_bits != 2'b11));
    return (on && capv < sel) ? capv : sel;
  endfunction

  function automatic longint lim_bytes(input logic [31:0] e);
    return (longint'(e) * WIN_BYTES) >> 16;
  endfunction

  task automatic step;
    @(posedge clk);
    if (synced) begin
      if (phase == WIN_CYC - 1) begin
        for (int p = 0; p < NPART; p++) cnt[p] = 0;
        phase = 0;
      end else begin
        if (req_valid) cnt[req_partid] += req_bytes;
        phase++;
      end
    end
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [63:0] d);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = d;
    step();
    cfg_wr_en   = 1'b0;
    rd_exp      = model_rd(d);
    #1;
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    logic [31:0] pats [6];
    logic [63:0] d;
    logic [31:0] e;
    logic [NPART-1:0] bexp;
    int guard;
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000; pats[2] = 32'hA5A5_5A5F;
    pats[3] = 32'h1234_8001; pats[4] = 32'h0001_000F; pats[5] = 32'h8000_7FF0;

    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = '0;
    cur_lvl = 2'd1; host_bits = 2'b00; streaming = 1'b0; hyp_active = 1'b1;
    gmax_lvl0 = 32'h0000_4000; gmax_lvl1 = 32'h0000_8000; gmax_strm = 32'h0001_2000;
    req_valid = 1'b0; req_partid = '0; req_bytes = '0;
    rd_exp = '0;
    for (int p = 0; p < NPART; p++) cnt[p] = 0;

    repeat (3) @(negedge clk);
    #1;
    check(cfg_rd_data == 64'd0, "R1 reg in reset", cfg_rd_data, 64'd0);
    check(part_blocked == '0, "R1 blocked in reset", 64'(part_blocked), 64'd0);
    rst_n = 1'b1;
    repeat (4) step();
    #1;
    check(cfg_rd_data == 64'd0, "R1 reg after reset", cfg_rd_data, 64'd0);
    check(part_blocked == '0, "R1 blocked after reset", 64'(part_blocked), 64'd0);
    check(eff_limit == gmax_lvl1, "R1 cap off after reset", 64'(eff_limit), 64'(gmax_lvl1));

    // register format sweep
    for (int i = 0; i < 6; i++) begin
      for (int h = 0; h < 2; h++) begin
        for (int en = 0; en < 2; en++) begin
          d = {h[0], en[0], 30'h2AAA_AAAA, pats[i]};
          cfg_write(d);
          check(cfg_rd_data[63:32] == rd_exp[63:32], "R2 upper word", cfg_rd_data, rd_exp);
          check(cfg_rd_data[31:0] == rd_exp[31:0], h ? "R3 scaled cap" : "R4 fraction cap",
                cfg_rd_data, rd_exp);
          check(cfg_rd_data[3:0] == 4'h0, "R5 low fraction bits", 64'(cfg_rd_data[3:0]), 64'd0);
        end
      end
    end

    // limit selection sweep
    for (int vs = 0; vs < 3; vs++) begin
      case (vs)
        0: begin gmax_lvl1 = 32'h0000_8000; gmax_lvl0 = 32'h0000_4000; gmax_strm = 32'h0001_2000; end
        1: begin gmax_lvl1 = 32'h0003_0000; gmax_lvl0 = 32'h0000_0100; gmax_strm = 32'h0000_5000; end
        default: begin gmax_lvl1 = 32'h0001_0000; gmax_lvl0 = 32'h0002_0000; gmax_strm = 32'h0000_FFF0; end
      endcase
      for (int h = 0; h < 2; h++) begin
        for (int en = 0; en < 2; en++) begin
          d = {h[0], en[0], 30'd0, (vs == 2) ? 32'h0001_8000 : 32'h0000_6ABC};
          cfg_write(d);
          for (int l = 0; l < 4; l++) begin
            for (int hb = 0; hb < 4; hb++) begin
              for (int s = 0; s < 2; s++) begin
                for (int hv = 0; hv < 2; hv++) begin
                  cur_lvl = l[1:0]; host_bits = hb[1:0]; streaming = s[0]; hyp_active = hv[0];
                  #1;
                  e = model_eff(rd_exp);
                  check(eff_limit == e, (en != 0 && hv != 0 && l < 2) ? "R7 cap select" : "R6 max select",
                        64'(eff_limit), 64'(e));
                end
              end
            end
          end
        end
      end
    end

    // find window phase
    cur_lvl = 2'd1; host_bits = 2'b00; streaming = 1'b0; hyp_active = 1'b1;
    gmax_lvl1 = 32'h0000_8000;
    cfg_write(64'h4000_0000_0000_4000);
    req_valid = 1'b1; req_partid = '0; req_bytes = 8'hFF;
    guard = 0;
    while (!part_blocked[0] && guard < 40) begin step(); #1; guard++; end
    req_valid = 1'b0;
    guard = 0;
    while (part_blocked[0] && guard < 40) begin step(); #1; guard++; end
    synced = 1;
    phase  = 0;
    for (int p = 0; p < NPART; p++) cnt[p] = 0;

    // usage scenarios
    lfsr = 16'hACE1;
    for (int sc = 0; sc < 4; sc++) begin
      req_valid = 1'b0;
      case (sc)
        0: begin cur_lvl = 2'd1; host_bits = 2'b00; gmax_lvl1 = 32'h0000_8000; cfg_write(64'h4000_0000_0000_4000); end
        1: begin cur_lvl = 2'd1; host_bits = 2'b00; gmax_lvl1 = 32'h0000_8000; cfg_write(64'h0000_0000_0000_4000); end
        2: begin cur_lvl = 2'd1; host_bits = 2'b00; gmax_lvl1 = 32'h0002_0000; cfg_write(64'hC000_0000_0001_8000); end
        default: begin cur_lvl = 2'd0; host_bits = 2'b11; gmax_lvl0 = 32'h0001_0000; cfg_write(64'h4000_0000_0000_4000); end
      endcase
      for (int c = 0; c < 3 * WIN_CYC; c++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        req_valid  = (lfsr[1:0] != 2'b00) || (phase == WIN_CYC - 1);
        req_partid = lfsr[3:2];
        req_bytes  = (phase == WIN_CYC - 1) ? 8'hFF : {lfsr[11:4]} & 8'h7F;
        #1;
        e = model_eff(rd_exp);
        for (int p = 0; p < NPART; p++) bexp[p] = (cnt[p] > lim_bytes(e));
        check(part_blocked == bexp, (phase == 0) ? "R9 window clear" : "R8 usage block",
              64'(part_blocked), 64'(bexp));
        check(req_blocked == bexp[req_partid], "R10 request flag",
              64'(req_blocked), 64'(bexp[req_partid]));
        step();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule